// File: doc/BRIEF.md
# DMA Channel Fixed-Priority Bus Arbiter

This block decides which DMA channel moves the next transfer unit and when the DMA engine hands the system bus back to the other masters. Every channel presents a request strobe, a mode bit (burst or cycle-steal), a flag saying whether the request comes from a peripheral, and a per-unit completion pulse with a terminal-count flag. The arbiter keeps one pending bit per channel, grants exactly one channel per transfer unit, and drives a bus-ownership signal toward the system bus arbiter.

Priority is fixed: a lower channel index always wins. A higher-priority channel that becomes ready during a lower channel's burst takes over at the next unit boundary. A burst preemptor runs to its end before the interrupted burst continues. A cycle-steal preemptor instead trades units one-for-one with the burst channel, and the bus is kept throughout. The bus is kept across unit boundaries for as long as any pending channel is in burst mode. Channels that only steal cycles give the bus back after every unit.

Address generation, the data path and the transfer counters live in the channels. The arbiter sees only the pulses they produce.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted and after reset is released with no request, `grant` is all zero and `bus_own` is low.
- R2: `grant` is one-hot while `bus_own` is high and zero otherwise. It stays unchanged until the granted channel pulses `unit_done`. A `unit_done` or `tc_zero` on any channel that is not granted has no effect.
- R3: When several channels are pending in burst mode, the lowest-indexed one is served first and runs all its units before the next one starts.
- R4: A higher-priority request that arrives during a lower-priority burst is granted the very next transfer unit.
- R5: If the preempting channel is in burst mode (mode bit 1), it completes all its units before the preempted burst resumes.
- R6: If the preempting channel is in cycle-steal mode (mode bit 0), grants alternate one unit at a time between it and the highest pending burst channel, starting with the burst channel after each cycle-steal unit.
- R7: `bus_own` stays high across a unit boundary whenever any pending channel is in burst mode. It falls only when no burst channel remains pending.
- R8: When only cycle-steal channels are pending, `bus_own` drops for at least one cycle after every transfer unit.
- R9: A channel stays pending through units completed with `tc_zero` low. The unit completed with `tc_zero` high retires it, and it receives no further grant.
- R10: A request with `periph_src` high is run in cycle-steal mode whatever its mode bit. It is accepted only on channels below `PERIPH_CH` (default 6) and is ignored on higher channels.
- R11: With the bus idle, a request strobed in one cycle is granted right after the next clock edge, and `bus_own` rises with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | NCH | One-cycle request strobe per channel |
| burst | input | NCH | Mode bit sampled with the request: 1 burst, 0 cycle-steal |
| periph_src | input | NCH | Request originates from a peripheral module |
| unit_done | input | NCH | End of one transfer unit of the channel |
| tc_zero | input | NCH | With unit_done: the channel's transfer count reached zero |
| grant | output | NCH | One-hot grant for the current transfer unit |
| bus_own | output | 1 | DMA holds the system bus |

## Verification
The assertions assume that a channel signals completion only while it holds the grant, and then at most once per unit, and that a request is not raised again for a channel that is still pending. The stub channels keep to the first rule by pulsing `unit_done` exactly one cycle after the unit starts. The only exception is one deliberate stray pulse on a pending but ungranted channel, which the design must ignore and which none of the assertions relies on. Requests are strobed only for idle channels, and every scenario drains completely before the next one begins.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_XFER = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dma_prio_enc.sv
// Lowest-index-first priority encoder built as a ripple of "seen" bits.
module dma_prio_enc #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] first,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign first[i]  = vec[i] & ~seen[i];
    assign seen[i+1] = seen[i] | vec[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/dma_req_track.sv
// Per-channel pending bit and latched mode.
module dma_req_track #(
  parameter int N         = 8,
  parameter int PERIPH_CH = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] burst,
  input  logic [N-1:0] periph_src,
  input  logic [N-1:0] retire,
  output logic [N-1:0] active_q,
  output logic [N-1:0] burst_q,
  output logic [N-1:0] active_nx,
  output logic [N-1:0] burst_nx
);
  logic [N-1:0] take;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      // peripheral-sourced requests only on low channels
      take[i]      = req[i] & ~active_q[i] & (~periph_src[i] | (i < PERIPH_CH));
      active_nx[i] = take[i] | (active_q[i] & ~retire[i]);
      // peripheral requests are forced to cycle-steal
      burst_nx[i]  = take[i] ? (burst[i] & ~periph_src[i]) : burst_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      burst_q  <= '0;
    end else begin
      active_q <= active_nx;
      if (|take) burst_q <= burst_nx;
    end
  end
endmodule

// File: rtl/dma_arb_fsm.sv
// Unit-boundary sequencer: holds the grant, chooses the next unit, owns the bus.
module dma_arb_fsm
  import dma_arb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] unit_done,
  input  logic [N-1:0] burst_q,
  input  logic [N-1:0] pick_all,
  input  logic         any_all,
  input  logic [N-1:0] pick_burst,
  input  logic         any_burst,
  output logic [N-1:0] grant_q,
  output logic         bus_own
);
  arb_state_e   state_q, state_d;
  logic [N-1:0] grant_d;
  logic         unit_end;
  logic         was_cs;

  assign unit_end = |(unit_done & grant_q);
  assign was_cs   = ~|(grant_q & burst_q);

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (any_all) begin
          state_d = ARB_XFER;
          grant_d = pick_all;
        end
      end
      ARB_XFER: begin
        if (unit_end) begin
          if (any_burst) begin
            // a cycle-steal unit hands the next unit to the best burst
            grant_d = was_cs ? pick_burst : pick_all;
          end else begin
            state_d = ARB_IDLE;
            grant_d = '0;
          end
        end
      end
      default: begin
        state_d = ARB_IDLE;
        grant_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  assign bus_own = (state_q == ARB_XFER);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH       = 8,
  parameter int PERIPH_CH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] burst,
  input  logic [NCH-1:0] periph_src,
  input  logic [NCH-1:0] unit_done,
  input  logic [NCH-1:0] tc_zero,
  output logic [NCH-1:0] grant,
  output logic           bus_own
);
  logic [1:0]     rst_pipe;
  logic           rst_int_n;
  logic [NCH-1:0] active_q, burst_q, active_nx, burst_nx;
  logic [NCH-1:0] retire;
  logic [NCH-1:0] pick_all, pick_burst;
  logic           any_all, any_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign retire = unit_done & tc_zero & grant;

  dma_req_track #(.N(NCH), .PERIPH_CH(PERIPH_CH)) u_track (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (req),
    .burst      (burst),
    .periph_src (periph_src),
    .retire     (retire),
    .active_q   (active_q),
    .burst_q    (burst_q),
    .active_nx  (active_nx),
    .burst_nx   (burst_nx)
  );

  dma_prio_enc #(.N(NCH)) u_enc_all (
    .vec   (active_nx),
    .first (pick_all),
    .any   (any_all)
  );

  dma_prio_enc #(.N(NCH)) u_enc_burst (
    .vec   (active_nx & burst_nx),
    .first (pick_burst),
    .any   (any_burst)
  );

  dma_arb_fsm #(.N(NCH)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .unit_done  (unit_done),
    .burst_q    (burst_q),
    .pick_all   (pick_all),
    .any_all    (any_all),
    .pick_burst (pick_burst),
    .any_burst  (any_burst),
    .grant_q    (grant),
    .bus_own    (bus_own)
  );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] grant,
  input logic           bus_own,
  input logic [NCH-1:0] unit_done,
  input logic [NCH-1:0] active_q,
  input logic [NCH-1:0] burst_q
);
  localparam logic [NCH-1:0] ONE = NCH'(1);

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_own_tracks_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own == (|grant));

  assert_grant_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && !(|(unit_done & grant))) |=> $stable(grant));

  assert_grant_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~active_q) == '0);

  assert_release_no_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_own) |-> ((active_q & burst_q) == '0));

  assert_burst_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|(unit_done & grant)) && (|(grant & burst_q)))
      |-> ((active_q & burst_q & (grant - ONE)) == '0));

  assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(unit_done & grant)) && !(|(grant & burst_q)) && ((active_q & burst_q) == '0))
      |=> (!bus_own || ((active_q & burst_q) != '0)));
endmodule

bind dma_prio_arb dma_arb_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .grant     (grant),
  .bus_own   (bus_own),
  .unit_done (unit_done),
  .active_q  (active_q),
  .burst_q   (burst_q)
);

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;
  localparam int NCH = 8;
  localparam int PCH = 6;
  localparam int GAP = 99;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] req, burst, periph_src, unit_done, tc_zero, grant;
  logic bus_own;

  always #5 clk = ~clk;

  dma_prio_arb #(.NCH(NCH), .PERIPH_CH(PCH)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .periph_src(periph_src),
    .unit_done(unit_done), .tc_zero(tc_zero), .grant(grant), .bus_own(bus_own)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cnt[NCH];
  int trig[NCH];
  bit md[NCH];
  bit pf[NCH];
  int spur;
  int logq[$];
  int expq[$];
  int first_git;
  bit own_bad;

  function automatic int bit_idx(logic [NCH-1:0] v);
    for (int i = 0; i < NCH; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic string q2s(int q[$]);
    string s = "";
    foreach (q[i]) s = {s, (q[i] == GAP) ? "G" : $sformatf("%0d", q[i]), " "};
    return s;
  endfunction

  task automatic clear_scn();
    for (int i = 0; i < NCH; i++) begin
      cnt[i] = 0; trig[i] = -1; md[i] = 1'b0; pf[i] = 1'b0;
    end
    spur = -1;
    logq.delete();
    expq.delete();
  endtask

  task automatic add_ch(int c, int n, int t, bit b, bit p);
    cnt[c] = n; trig[c] = t; md[c] = b; pf[c] = p;
  endtask

  task automatic run_scn();
    int rem[NCH];
    int hold = 0;
    int k;
    bit first_done = 1'b0;
    bit spur_armed = (spur >= 0);
    logic [NCH-1:0] prev_g = '0;
    first_git = -1;
    own_bad = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      rem[i] = cnt[i];
      burst[i] = md[i];
      periph_src[i] = pf[i];
    end
    for (int it = 0; it < 60; it++) begin
      @(posedge clk); #1;
      if (bus_own != (grant != '0)) own_bad = 1'b1;
      if (grant != '0) begin
        if (first_git < 0) first_git = it;
        if (hold == 0) logq.push_back(bit_idx(grant));
      end else if (prev_g != '0) begin
        logq.push_back(GAP);
      end
      prev_g = grant;
      req = '0; unit_done = '0; tc_zero = '0;
      for (int i = 0; i < NCH; i++) if (it == 0 && trig[i] == 0) req[i] = 1'b1;
      if (grant != '0) begin
        k = bit_idx(grant);
        if (hold == 1) begin
          unit_done[k] = 1'b1;
          rem[k]--;
          tc_zero[k] = (rem[k] == 0);
          hold = 0;
          if (!first_done) begin
            first_done = 1'b1;
            for (int i = 0; i < NCH; i++) if (trig[i] == 1) req[i] = 1'b1;
          end
        end else begin
          hold = 1;
          if (spur_armed && first_done && k != spur) begin
            unit_done[spur] = 1'b1;
            tc_zero[spur] = 1'b1;
            spur_armed = 1'b0;
          end
        end
      end
    end
    req = '0; unit_done = '0; tc_zero = '0;
  endtask

  task automatic check_seq(string tag, string what);
    bit ok;
    n_cmp++;
    ok = (logq.size() == expq.size()) && !own_bad;
    if (ok) foreach (expq[i]) if (logq[i] != expq[i]) ok = 1'b0;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual [%s] own_bad=%0d expected [%s]", tag, what,
               q2s(logq), own_bad, q2s(expq));
    end
  endtask

  task automatic check_val(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req = '0; burst = '0; periph_src = '0; unit_done = '0; tc_zero = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_val("R1", "grant in reset", int'(grant), 0);
    check_val("R1", "bus_own in reset", int'(bus_own), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_val("R1", "grant after release", int'(grant), 0);
    check_val("R1", "bus_own after release", int'(bus_own), 0);

    // R9/R7/R11: lone burst on each channel
    for (int c = 0; c < NCH; c++) begin
      clear_scn(); add_ch(c, 3, 0, 1'b1, 1'b0);
      repeat (3) expq.push_back(c);
      expq.push_back(GAP);
      run_scn();
      check_seq("R9", $sformatf("lone burst ch%0d", c));
      check_val("R11", $sformatf("grant latency ch%0d", c), first_git, 1);
    end

    // R8: lone cycle-steal on each channel
    for (int c = 0; c < NCH; c++) begin
      clear_scn(); add_ch(c, 3, 0, 1'b0, 1'b0);
      for (int u = 0; u < 3; u++) begin expq.push_back(c); expq.push_back(GAP); end
      run_scn();
      check_seq("R8", $sformatf("lone cycle-steal ch%0d", c));
    end

    // R4/R5: burst preempts burst, every pair
    for (int h = 0; h < NCH; h++) begin
      for (int l = h + 1; l < NCH; l++) begin
        clear_scn();
        add_ch(l, 4, 0, 1'b1, 1'b0);
        add_ch(h, 2, 1, 1'b1, 1'b0);
        expq.push_back(l);
        repeat (2) expq.push_back(h);
        repeat (3) expq.push_back(l);
        expq.push_back(GAP);
        run_scn();
        check_seq("R5", $sformatf("burst %0d preempts burst %0d", h, l));
      end
    end

    // R4/R6/R7: cycle-steal preempts burst, every pair
    for (int h = 0; h < NCH; h++) begin
      for (int l = h + 1; l < NCH; l++) begin
        clear_scn();
        add_ch(l, 4, 0, 1'b1, 1'b0);
        add_ch(h, 2, 1, 1'b0, 1'b0);
        expq.push_back(l);
        for (int u = 0; u < 2; u++) begin expq.push_back(h); expq.push_back(l); end
        expq.push_back(l);
        expq.push_back(GAP);
        run_scn();
        check_seq("R6", $sformatf("cycle-steal %0d interleaves burst %0d", h, l));
      end
    end

    // R3: three simultaneous bursts
    clear_scn();
    add_ch(5, 2, 0, 1'b1, 1'b0); add_ch(2, 2, 0, 1'b1, 1'b0); add_ch(7, 2, 0, 1'b1, 1'b0);
    expq = '{2, 2, 5, 5, 7, 7, GAP};
    run_scn();
    check_seq("R3", "bursts 2,5,7 together");

    // R6: cycle-steal 0 and burst 3 requested together
    clear_scn();
    add_ch(0, 2, 0, 1'b0, 1'b0); add_ch(3, 2, 0, 1'b1, 1'b0);
    expq = '{0, 3, 0, 3, GAP};
    run_scn();
    check_seq("R6", "cycle-steal 0 with burst 3");

    // R10: peripheral requests on channels at or above the limit are ignored
    for (int c = PCH; c < NCH; c++) begin
      clear_scn(); add_ch(c, 2, 0, 1'b1, 1'b1);
      run_scn();
      check_seq("R10", $sformatf("peripheral request ch%0d ignored", c));
    end

    // R10: peripheral requests below the limit run as cycle-steal
    for (int c = 0; c < PCH; c++) begin
      clear_scn(); add_ch(c, 2, 0, 1'b1, 1'b1);
      expq = '{c, GAP, c, GAP};
      run_scn();
      check_seq("R10", $sformatf("peripheral request ch%0d forced cycle-steal", c));
    end

    // R2: stray done with terminal count on a pending, ungranted channel
    clear_scn();
    add_ch(4, 3, 0, 1'b1, 1'b0);
    add_ch(1, 2, 1, 1'b1, 1'b0);
    spur = 4;
    expq = '{4, 1, 1, 4, 4, GAP};
    run_scn();
    check_seq("R2", "stray done on ungranted ch4 ignored");

    finish_run();
  end
endmodule